// File: doc/BRIEF.md
# RSSI Threshold Monitor with Clear-Channel Detection

This block sits beside a radio receiver's signal-strength estimator. It compares received signal strength codes against a programmable threshold and produces several receive-control signals from the result:

- a sticky interrupt flag;
- a live clear-channel output and a remembered copy of it;
- a one-cycle "no signal" event that a channel-hopping controller uses to retune;
- a gate that freezes the demodulated data output while the channel is quiet.

Two strength values arrive. The current value is refreshed by an update strobe. The latched value is captured once per receive session and is valid during a latch-done strobe. The interrupt and both clear-channel outputs depend only on the current value. The latched value feeds only the abort path, which is a three-state session machine.

The session machine has three states:

- PH_LISTEN: a session has started and no latch has been seen yet.
- PH_RECEIVE: the latch check passed, or the check is disabled.
- PH_TIMEOUT: the latched value was below the threshold.

It has four transitions:

- LISTEN→RECEIVE: latch-done arrives and the check is disabled, or the latched value is at or above the threshold.
- LISTEN→TIMEOUT: latch-done arrives, the check is enabled, and the latched value is below the threshold. The event pulse fires on this transition.
- any→LISTEN: on restart.
- Otherwise the state holds.

Top module: `rssi_thresh_mon`

## Requirements
- R1: Every strength code and the threshold are unsigned. The live comparison is strict: a current value equal to the threshold counts as not above. The registered current value is loaded on `cur_upd` and is zero after reset and after restart. The interrupt `irq` rises one cycle after the live comparison is true. The latched value never sets `irq`.
- R2: `irq` stays high until a cycle with `irq_clr` or `rx_restart`, and is low in the cycle after that.
- R3: When `irq_clr` coincides with a live above-threshold condition, the set wins and `irq` stays high.
- R4: `cca` is high in the same cycle whenever the registered current value is strictly greater than `thresh`, and low otherwise.
- R5: `cca_latched` goes high in the cycle after `cca` is high. It holds until a cycle with `sync_det` or `rx_restart`, which clears it with priority over a new set.
- R6: In PH_LISTEN, a `lat_done` with `chk_latch_en` high and `lat_rssi` strictly below `thresh` moves the machine to PH_TIMEOUT. The next cycle shows `rx_timeout` high and `inv_preamble` high for exactly one cycle.
- R7: A `lat_done` with `lat_rssi` equal to or above `thresh`, or with `chk_latch_en` low, moves the machine to PH_RECEIVE with no event and no timeout.
- R8: With `squelch_en` high and `cca` low, `rx_data_out` holds its previous value regardless of `rx_data_in`.
- R9: With `squelch_en` low, or with `cca` high, `rx_data_out` follows `rx_data_in` in the same cycle.
- R10: `lat_done` outside PH_LISTEN is ignored: no event and no change of state.
- R11: `rx_restart` returns the machine to PH_LISTEN and clears `irq`, `cca_latched` and the registered current value in the next cycle. It has priority over every other input.
- R12: During and after reset, all outputs are low and the machine is in PH_LISTEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_rssi | input | RSSI_W | Current strength code |
| cur_upd | input | 1 | Load strobe for `cur_rssi` |
| lat_rssi | input | RSSI_W | Latched strength code, valid with `lat_done` |
| lat_done | input | 1 | Latch event strobe |
| thresh | input | RSSI_W | Threshold code |
| chk_latch_en | input | 1 | Enable the latched no-signal check |
| squelch_en | input | 1 | Enable data squelch |
| irq_clr | input | 1 | Interrupt clear pulse |
| sync_det | input | 1 | Sync word detected pulse |
| rx_restart | input | 1 | Receiver restart pulse |
| rx_data_in | input | 1 | Raw demodulated data |
| irq | output | 1 | Sticky above-threshold interrupt |
| cca | output | 1 | Live clear-channel (above threshold) |
| cca_latched | output | 1 | Remembered clear-channel assertion |
| inv_preamble | output | 1 | One-cycle no-signal event |
| rx_timeout | output | 1 | Session in PH_TIMEOUT |
| rx_data_out | output | 1 | Squelched data |

## Verification
The assertions check these properties on every cycle:

- setting and holding of `irq`, including set-over-clear;
- the capture of `cca` into `cca_latched`;
- the single-cycle width of `inv_preamble` and that it coincides with the timeout;
- the hold of `rx_data_out` while squelched;
- the clearing effect of a restart.

Some behaviours depend on numeric relations that only the bench's cycle-by-cycle reference model can show:

- the strict comparison at the equal-to-threshold boundary on the live path, against the inclusive one on the latch path;
- that the latched value never reaches `irq`;
- that a second latch strobe in the same session is ignored.

// File: rtl/rssi_mon_pkg.sv
package rssi_mon_pkg;

    typedef enum logic [1:0] {
        PH_LISTEN  = 2'd0,
        PH_RECEIVE = 2'd1,
        PH_TIMEOUT = 2'd2
    } rx_phase_e;

    localparam int CMP_COUNT = 2;

endpackage

// File: rtl/rssi_gt.sv
module rssi_gt #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt
);
    assign gt = (a > b);
endmodule

// File: rtl/rssi_flags.sv
module rssi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic live_above,
    input  logic irq_clr,
    input  logic sync_det,
    input  logic rx_restart,
    output logic irq,
    output logic cca_latched
);
    logic irq_q, ccal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            ccal_q <= 1'b0;
        end else if (rx_restart) begin
            irq_q  <= 1'b0;
            ccal_q <= 1'b0;
        end else begin
            // a set in the same cycle as a clear wins
            irq_q  <= live_above | (irq_q & ~irq_clr);
            ccal_q <= sync_det ? 1'b0 : (live_above | ccal_q);
        end
    end

    assign irq         = irq_q;
    assign cca_latched = ccal_q;
endmodule

// File: rtl/rssi_squelch.sv
module rssi_squelch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic above,
    input  logic din,
    output logic dout
);
    logic hold_q;

    assign dout = (enable && !above) ? hold_q : din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= dout;
    end
endmodule

// File: rtl/rssi_thresh_mon.sv
module rssi_thresh_mon
    import rssi_mon_pkg::*;
#(
    parameter int RSSI_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSSI_W-1:0] cur_rssi,
    input  logic              cur_upd,
    input  logic [RSSI_W-1:0] lat_rssi,
    input  logic              lat_done,
    input  logic [RSSI_W-1:0] thresh,
    input  logic              chk_latch_en,
    input  logic              squelch_en,
    input  logic              irq_clr,
    input  logic              sync_det,
    input  logic              rx_restart,
    input  logic              rx_data_in,
    output logic              irq,
    output logic              cca,
    output logic              cca_latched,
    output logic              inv_preamble,
    output logic              rx_timeout,
    output logic              rx_data_out
);
    localparam int CMP_LIVE = 0;
    localparam int CMP_LAT  = 1;

    logic [RSSI_W-1:0] cur_q;
    logic [RSSI_W-1:0] cmp_a [CMP_COUNT];
    logic [RSSI_W-1:0] cmp_b [CMP_COUNT];
    logic [CMP_COUNT-1:0] cmp_gt;
    logic live_above, lat_below;

    rx_phase_e state_q, state_d;
    logic      inv_q;

    // current strength register, zeroed by a restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cur_q <= '0;
        else if (rx_restart) cur_q <= '0;
        else if (cur_upd)    cur_q <= cur_rssi;
    end

    // live path: current > thresh; latch path: thresh > latched
    assign cmp_a[CMP_LIVE] = cur_q;
    assign cmp_b[CMP_LIVE] = thresh;
    assign cmp_a[CMP_LAT]  = thresh;
    assign cmp_b[CMP_LAT]  = lat_rssi;

    generate
        for (genvar g = 0; g < CMP_COUNT; g++) begin : g_cmp
            rssi_gt #(.W(RSSI_W)) u_gt (
                .a  (cmp_a[g]),
                .b  (cmp_b[g]),
                .gt (cmp_gt[g])
            );
        end
    endgenerate

    assign live_above = cmp_gt[CMP_LIVE];
    assign lat_below  = cmp_gt[CMP_LAT];

    // session machine: next state
    always_comb begin
        state_d = state_q;
        if (rx_restart) begin
            state_d = PH_LISTEN;
        end else begin
            unique case (state_q)
                PH_LISTEN: begin
                    if (lat_done) begin
                        if (chk_latch_en && lat_below) state_d = PH_TIMEOUT;
                        else                            state_d = PH_RECEIVE;
                    end
                end
                PH_RECEIVE: state_d = PH_RECEIVE;
                PH_TIMEOUT: state_d = PH_TIMEOUT;
                default:    state_d = PH_LISTEN;
            endcase
        end
    end

    // session machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LISTEN;
        else        state_q <= state_d;
    end

    // session machine: registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inv_q <= 1'b0;
        else        inv_q <= (state_q == PH_LISTEN) && (state_d == PH_TIMEOUT);
    end

    assign inv_preamble = inv_q;
    assign rx_timeout   = (state_q == PH_TIMEOUT);
    assign cca          = live_above;

    rssi_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_above  (live_above),
        .irq_clr     (irq_clr),
        .sync_det    (sync_det),
        .rx_restart  (rx_restart),
        .irq         (irq),
        .cca_latched (cca_latched)
    );

    rssi_squelch u_sq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (squelch_en),
        .above  (live_above),
        .din    (rx_data_in),
        .dout   (rx_data_out)
    );
endmodule

// File: rtl/rssi_mon_chk.sv
module rssi_mon_chk #(
    parameter int RSSI_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RSSI_W-1:0] cur_rssi,
    input logic              cur_upd,
    input logic [RSSI_W-1:0] lat_rssi,
    input logic              lat_done,
    input logic [RSSI_W-1:0] thresh,
    input logic              chk_latch_en,
    input logic              squelch_en,
    input logic              irq_clr,
    input logic              sync_det,
    input logic              rx_restart,
    input logic              rx_data_in,
    input logic              irq,
    input logic              cca,
    input logic              cca_latched,
    input logic              inv_preamble,
    input logic              rx_timeout,
    input logic              rx_data_out
);
    logic prev_out, prev_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_out <= 1'b0;
            prev_ok  <= 1'b0;
        end else begin
            prev_out <= rx_data_out;
            prev_ok  <= 1'b1;
        end
    end

    // R1
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cca && !rx_restart) |=> irq);

    // R2
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr && !rx_restart) |=> irq);

    // R3
    set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cca && irq_clr && !rx_restart) |=> irq);

    // R5
    ccal_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cca && !sync_det && !rx_restart) |=> cca_latched);

    // R6
    inv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_preamble |=> !inv_preamble);

    // R6
    inv_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_preamble |-> rx_timeout);

    // R8
    squelch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && squelch_en && !cca) |-> (rx_data_out == prev_out));

    // R11
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_restart |=> (!irq && !cca_latched && !rx_timeout && !cca));
endmodule

bind rssi_thresh_mon rssi_mon_chk #(.RSSI_W(RSSI_W)) i_chk (.*);

// File: tb/test_rssi_thresh_mon.sv
module test_rssi_thresh_mon;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cur_rssi = '0, lat_rssi = '0, thresh = '0;
    logic cur_upd = 0, lat_done = 0, chk_latch_en = 0, squelch_en = 0;
    logic irq_clr = 0, sync_det = 0, rx_restart = 0, rx_data_in = 0;
    logic irq, cca, cca_latched, inv_preamble, rx_timeout, rx_data_out;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_cur = 0, m_phase = 0, m_hold = 0;
    bit m_irq = 0, m_ccal = 0, m_inv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_thresh_mon #(.RSSI_W(W)) i_rssi_thresh_mon (
        .clk(clk), .rst_n(rst_n), .cur_rssi(cur_rssi), .cur_upd(cur_upd),
        .lat_rssi(lat_rssi), .lat_done(lat_done), .thresh(thresh),
        .chk_latch_en(chk_latch_en), .squelch_en(squelch_en),
        .irq_clr(irq_clr), .sync_det(sync_det), .rx_restart(rx_restart),
        .rx_data_in(rx_data_in), .irq(irq), .cca(cca),
        .cca_latched(cca_latched), .inv_preamble(inv_preamble),
        .rx_timeout(rx_timeout), .rx_data_out(rx_data_out)
    );

    function automatic bit exp_cca();
        return m_cur > int'(thresh);
    endfunction

    function automatic bit exp_dout();
        return (squelch_en && !exp_cca()) ? m_hold[0] : rx_data_in;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cur = 0; m_phase = 0; m_hold = 0;
            m_irq = 0; m_ccal = 0; m_inv = 0;
        end else begin
            bit above;
            above = exp_cca();
            m_hold = exp_dout();
            m_inv = 0;
            if (rx_restart) begin
                m_irq = 0; m_ccal = 0; m_phase = 0; m_cur = 0;
            end else begin
                m_irq  = above || (m_irq && !irq_clr);
                m_ccal = sync_det ? 0 : (above || m_ccal);
                if (m_phase == 0 && lat_done) begin
                    if (chk_latch_en && int'(lat_rssi) < int'(thresh)) begin
                        m_phase = 2; m_inv = 1;
                    end else m_phase = 1;
                end
                if (cur_upd) m_cur = cur_rssi;
            end
        end
    end

    task automatic chk(string tag, int act, int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp_v);
        end
    endtask

    task automatic compare_all();
        chk("R1 R2 R3 irq", irq, m_irq);
        chk("R4 cca", cca, exp_cca());
        chk("R5 cca_latched", cca_latched, m_ccal);
        chk("R6 R7 R10 inv_preamble", inv_preamble, m_inv);
        chk("R6 R11 rx_timeout", rx_timeout, m_phase == 2);
        chk("R8 R9 rx_data_out", rx_data_out, exp_dout());
    endtask

    // inputs set after a falling edge; compare, then advance one cycle
    task automatic cyc();
        #1 compare_all();
        @(negedge clk);
        cur_upd = 0; lat_done = 0; irq_clr = 0; sync_det = 0; rx_restart = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        thresh = 8'd100;
        @(negedge clk);
        // R12: outputs low during reset
        chk("R12 reset", {irq, cca, cca_latched, inv_preamble, rx_timeout, rx_data_out}, 0);
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R4: below, equal, above
        cur_rssi = 50;  cur_upd = 1; cyc(); cyc();
        cur_rssi = 100; cur_upd = 1; cyc(); cyc();
        cur_rssi = 101; cur_upd = 1; cyc(); cyc(); cyc();
        // R2: drops below, irq and cca_latched hold
        cur_rssi = 20; cur_upd = 1; cyc(); cyc(); cyc();
        irq_clr = 1; cyc(); cyc();
        // R3: set wins over clear
        cur_rssi = 150; cur_upd = 1; cyc();
        irq_clr = 1; cyc(); cyc();
        // R5: sync clears latched copy once live is low
        cur_rssi = 10; cur_upd = 1; cyc();
        sync_det = 1; cyc(); cyc();
        // R8 R9: squelch
        squelch_en = 1;
        for (int i = 0; i < 6; i++) begin rx_data_in = i[0]; cyc(); end
        cur_rssi = 200; cur_upd = 1; cyc();
        for (int i = 0; i < 6; i++) begin rx_data_in = ~i[0]; cyc(); end
        squelch_en = 0; cur_rssi = 5; cur_upd = 1; cyc();
        for (int i = 0; i < 4; i++) begin rx_data_in = i[1]; cyc(); end
        // R1: latched high never sets irq; R7 equal latched continues
        rx_restart = 1; cyc(); cyc();
        chk_latch_en = 1; lat_rssi = 100; lat_done = 1; cyc(); cyc(); cyc();
        // R10: second latch in session ignored
        lat_rssi = 3; lat_done = 1; cyc(); cyc();
        // R6: below threshold -> event and timeout
        rx_restart = 1; cyc();
        lat_rssi = 99; lat_done = 1; cyc(); cyc(); cyc();
        lat_done = 1; cyc(); cyc();
        // R11: restart leaves timeout
        rx_restart = 1; cyc(); cyc();
        // R7: check disabled
        chk_latch_en = 0; lat_rssi = 0; lat_done = 1; cyc(); cyc();
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            cur_rssi = W'($urandom_range(80, 120));
            cur_upd = ($urandom_range(0, 2) == 0);
            lat_rssi = W'($urandom_range(90, 110));
            lat_done = ($urandom_range(0, 7) == 0);
            thresh = W'($urandom_range(95, 105));
            chk_latch_en = $urandom_range(0, 1);
            squelch_en = $urandom_range(0, 1);
            irq_clr = ($urandom_range(0, 5) == 0);
            sync_det = ($urandom_range(0, 9) == 0);
            rx_restart = ($urandom_range(0, 19) == 0);
            rx_data_in = $urandom_range(0, 1);
            cyc();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule